// File: doc/BRIEF.md
# Iterative Degree-Input Sine/Cosine Rotator

This block computes the sine and cosine of a small angle with rotation-mode CORDIC. Each clock cycle it performs one shift-and-add micro-rotation, so it needs no multiplier. The angle arrives in degrees as a separate sign pin and a 16-bit unsigned magnitude with 8 fractional bits. The block returns both results as 17-bit two's complement words scaled so that 1.0 reads as 32768.

A computation is started by holding the synchronous reset high for at least one rising edge while the angle is on the input pins. At every reset edge the block loads the angle into a signed residual register, loads y with zero and loads x with the CORDIC gain constant, so no scaling is needed afterwards. When reset is released the block runs sixteen micro-rotations. The residual is driven towards zero using an arctangent table held in degrees.

The result port acts as the valid side of a stream that has no back-pressure. `out_valid` rises after the last micro-rotation and stays high, with both result words frozen, until the next reset. A consumer may therefore take the result on any cycle in that window, and no ready signal is needed.

Top module: `cordic_sincos`

## Requirements
- R1: The angle is read as a sign-magnitude value in degrees: `ang_neg` = 1 means negative, and `ang_mag` is unsigned with 8 fractional bits, so the angle equals ±`ang_mag`/256. The value used is the one present at the last rising edge at which `rst` is high.
- R2: The outputs `cos_out` and `sin_out` are 17-bit two's complement words with 1.0 = 32768. For every angle in −45..+45 degrees, each output is within 4 LSB of the real cosine or sine of the angle.
- R3: Reset is synchronous and active high. After any rising edge at which `rst` is high, `out_valid` = 0, `sin_out` = 0 and `cos_out` holds the gain constant 0.607253 × 32768 (19898 ± 1).
- R4: After the first 15 rising edges with `rst` low, `out_valid` is 0. It is 1 after the 16th such edge.
- R5: Once `out_valid` is 1 and while `rst` stays low, `out_valid`, `cos_out` and `sin_out` hold their values, and changes on `ang_neg` or `ang_mag` have no effect on them.
- R6: Negative zero (`ang_neg` = 1, `ang_mag` = 0) gives cosine ≈ 32768 and sine ≈ 0, within the tolerance of R2.
- R7: At the endpoints ±45.0 degrees (`ang_mag` = 11520), both outputs are within the tolerance of R2, and `sin_out` has the sign of the angle.
- R8: A new reset after a completed computation starts a fresh one, with no state carried over from the earlier angle.
- R9: While `out_valid` is 1, `cos_out` is strictly positive for every supported angle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; loads the angle and starts a run when released |
| ang_neg | input | 1 | Angle sign, 1 = negative |
| ang_mag | input | 16 | Angle magnitude in degrees, 8 integer and 8 fractional bits |
| cos_out | output | 17 | Cosine, two's complement, 1.0 = 32768 |
| sin_out | output | 17 | Sine, two's complement, 1.0 = 32768 |
| out_valid | output | 1 | Results are final and held |

## Verification
The reset-state values are due one edge after `rst` is sampled high, and the results are due exactly 16 rising edges after the first edge that sees `rst` low. The bench changes its inputs and samples the outputs on falling edges. It releases reset, counts 15 falling edges and checks that `out_valid` is still low. After one more falling edge it checks `out_valid` and compares both results with real-valued sine and cosine. Hold checks change the angle pins after completion, let three further edges pass and then compare the outputs with the values recorded earlier.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  // Fractional bits used by the arctangent constants below.
  localparam int TBL_FRAC = 12;
  // Number of entries the constant function can return.
  localparam int TBL_MAX = 16;
  // Product of cos(atan(2^-i)) over all iterations.
  localparam real GAIN_K = 0.6072529350088813;

  // atan(2^-idx) in degrees, scaled by 2^TBL_FRAC and rounded.
  function automatic int atan_deg_q12(input int idx);
    case (idx)
      0:  atan_deg_q12 = 184320;
      1:  atan_deg_q12 = 108810;
      2:  atan_deg_q12 = 57492;
      3:  atan_deg_q12 = 29184;
      4:  atan_deg_q12 = 14649;
      5:  atan_deg_q12 = 7331;
      6:  atan_deg_q12 = 3667;
      7:  atan_deg_q12 = 1833;
      8:  atan_deg_q12 = 917;
      9:  atan_deg_q12 = 458;
      10: atan_deg_q12 = 229;
      11: atan_deg_q12 = 115;
      12: atan_deg_q12 = 57;
      13: atan_deg_q12 = 29;
      14: atan_deg_q12 = 14;
      15: atan_deg_q12 = 7;
      default: atan_deg_q12 = 0;
    endcase
  endfunction

endpackage

// File: rtl/cordic_angle_in.sv
// Converts the sign-magnitude degree input into a signed residual angle
// that has extra fractional guard bits.
module cordic_angle_in #(
  parameter int MAG_W    = 16,
  parameter int MAG_FRAC = 8,
  parameter int GUARD    = 4,
  localparam int ZW      = MAG_W + GUARD + 1
) (
  input  logic               neg,
  input  logic [MAG_W-1:0]   mag,
  output logic signed [ZW-1:0] z0
);

  logic signed [ZW-1:0] mag_ext;

  assign mag_ext = $signed({{(ZW-MAG_W){1'b0}}, mag}) <<< GUARD;
  assign z0      = neg ? -mag_ext : mag_ext;

endmodule

// File: rtl/cordic_atan_rom.sv
// Arctangent-in-degrees constants, rescaled to the residual format.
module cordic_atan_rom #(
  parameter int DEPTH = 16,
  parameter int ZW    = 21,
  parameter int ZFRAC = 12,
  parameter int IW    = 5,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [IW-1:0]        iter,
  output logic signed [ZW-1:0] atan
);
  import cordic_pkg::*;

  logic signed [ZW-1:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    if (ZFRAC <= TBL_FRAC) begin : g_shr
      assign tbl[g] = ZW'(atan_deg_q12(g) >>> (TBL_FRAC - ZFRAC));
    end else begin : g_shl
      assign tbl[g] = ZW'(atan_deg_q12(g) <<< (ZFRAC - TBL_FRAC));
    end
  end

  assign atan = (iter < IW'(DEPTH)) ? tbl[iter[AW-1:0]] : '0;

endmodule

// File: rtl/cordic_microrot.sv
// One rotation-mode micro-rotation: shift, add/subtract, update residual.
module cordic_microrot #(
  parameter int DW = 21,
  parameter int ZW = 21,
  parameter int IW = 5
) (
  input  logic signed [DW-1:0] x_in,
  input  logic signed [DW-1:0] y_in,
  input  logic signed [ZW-1:0] z_in,
  input  logic [IW-1:0]        iter,
  input  logic signed [ZW-1:0] atan,
  output logic signed [DW-1:0] x_out,
  output logic signed [DW-1:0] y_out,
  output logic signed [ZW-1:0] z_out
);

  logic                 rot_pos;
  logic signed [DW-1:0] x_sh;
  logic signed [DW-1:0] y_sh;

  assign rot_pos = ~z_in[ZW-1];
  assign x_sh    = x_in >>> iter;
  assign y_sh    = y_in >>> iter;

  always_comb begin
    if (rot_pos) begin
      x_out = x_in - y_sh;
      y_out = y_in + x_sh;
      z_out = z_in - atan;
    end else begin
      x_out = x_in + y_sh;
      y_out = y_in - x_sh;
      z_out = z_in + atan;
    end
  end

endmodule

// File: rtl/cordic_seq.sv
// Iteration counter: restarts at each reset edge, stops after ITERS steps.
module cordic_seq #(
  parameter int ITERS = 16,
  localparam int IW   = $clog2(ITERS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [IW-1:0] iter,
  output logic          step,
  output logic          done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      iter <= '0;
    end else if (step) begin
      iter <= iter + IW'(1);
    end
  end

  assign done = (iter == IW'(ITERS));
  assign step = ~done;

  // R4: the counter never runs past the final iteration
  p_iter_bound_r4: assert property (@(posedge clk) disable iff (rst)
    iter <= IW'(ITERS));

endmodule

// File: rtl/cordic_sincos.sv
module cordic_sincos #(
  parameter int ITERS    = 16,
  parameter int OUT_W    = 17,
  parameter int MAG_W    = 16,
  parameter int MAG_FRAC = 8,
  parameter int GUARD    = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ang_neg,
  input  logic [MAG_W-1:0]        ang_mag,
  output logic signed [OUT_W-1:0] cos_out,
  output logic signed [OUT_W-1:0] sin_out,
  output logic                    out_valid
);
  import cordic_pkg::*;

  localparam int IW     = $clog2(ITERS + 1);
  localparam int DW     = OUT_W + GUARD;
  localparam int XFRAC  = OUT_W - 2 + GUARD;
  localparam int ZW     = MAG_W + GUARD + 1;
  localparam int ZFRAC  = MAG_FRAC + GUARD;
  localparam int K_INIT = $rtoi(GAIN_K * (2.0 ** XFRAC) + 0.5);

  logic signed [DW-1:0] x_q, y_q, x_d, y_d;
  logic signed [ZW-1:0] z_q, z_d, z_load, atan;
  logic [IW-1:0]        iter;
  logic                 step;
  logic                 done;

  cordic_angle_in #(
    .MAG_W(MAG_W), .MAG_FRAC(MAG_FRAC), .GUARD(GUARD)
  ) u_ang (
    .neg(ang_neg), .mag(ang_mag), .z0(z_load)
  );

  cordic_seq #(.ITERS(ITERS)) u_seq (
    .clk(clk), .rst(rst), .iter(iter), .step(step), .done(done)
  );

  cordic_atan_rom #(
    .DEPTH(ITERS), .ZW(ZW), .ZFRAC(ZFRAC), .IW(IW)
  ) u_rom (
    .iter(iter), .atan(atan)
  );

  cordic_microrot #(.DW(DW), .ZW(ZW), .IW(IW)) u_rot (
    .x_in(x_q), .y_in(y_q), .z_in(z_q), .iter(iter), .atan(atan),
    .x_out(x_d), .y_out(y_d), .z_out(z_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= DW'(K_INIT);
      y_q <= '0;
      z_q <= z_load;
    end else if (step) begin
      x_q <= x_d;
      y_q <= y_d;
      z_q <= z_d;
    end
  end

  assign cos_out   = x_q[DW-1:GUARD];
  assign sin_out   = y_q[DW-1:GUARD];
  assign out_valid = done;

  // Independent cycle counter used only to check the latency.
  logic [IW-1:0] chk_cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_cnt <= '0;
    end else if (chk_cnt != IW'(ITERS)) begin
      chk_cnt <= chk_cnt + IW'(1);
    end
  end

  // R3: a reset edge clears valid and the sine accumulator
  p_reset_state_r3: assert property (@(posedge clk)
    rst |=> (!out_valid && sin_out == '0));

  // R4: valid tracks the cycles elapsed since reset release
  p_valid_latency_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid == (chk_cnt == IW'(ITERS)));

  // R5: completed results are frozen until the next reset
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> (out_valid && $stable(cos_out) && $stable(sin_out)));

  // R9: final cosine is positive over the supported range
  p_cos_positive_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (!cos_out[OUT_W-1] && cos_out != '0));

endmodule

// File: tb/sim_cordic_sincos.sv
module sim_cordic_sincos;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               ang_neg = 1'b0;
  logic [15:0]        ang_mag = '0;
  logic signed [16:0] cos_out;
  logic signed [16:0] sin_out;
  logic               out_valid;

  int checks = 0;
  int errors = 0;

  localparam real PI  = 3.141592653589793;
  localparam real TOL = 4.0;

  always #2 clk = ~clk;

  cordic_sincos u0 (
    .clk(clk), .rst(rst), .ang_neg(ang_neg), .ang_mag(ang_mag),
    .cos_out(cos_out), .sin_out(sin_out), .out_valid(out_valid)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_near(input string tag, input int act, input real exp, input real tol);
    real d;
    checks++;
    d = real'(act) - exp;
    if (d < 0.0) d = -d;
    if (d > tol) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, $rtoi(exp));
    end
  endtask

  // Reset with the angle applied, release, then check timing and values.
  task automatic run(input logic neg, input logic [15:0] mag, input bit hold,
                     input string tag);
    real ang, rad;
    int  c_keep, s_keep;
    @(negedge clk);
    rst = 1'b1; ang_neg = neg; ang_mag = mag;
    @(negedge clk);
    // R3: reset state after a reset edge
    check_eq({tag, " R3 valid in reset"}, int'(out_valid), 0);
    check_eq({tag, " R3 sin in reset"}, int'(sin_out), 0);
    check_near({tag, " R3 cos gain in reset"}, int'(cos_out), 0.6072529350088813 * 32768.0, 1.0);
    rst = 1'b0;
    repeat (15) @(negedge clk);
    // R4: not yet valid after 15 low edges
    check_eq({tag, " R4 valid early"}, int'(out_valid), 0);
    @(negedge clk);
    // R4: valid after the 16th low edge
    check_eq({tag, " R4 valid on time"}, int'(out_valid), 1);
    ang = (neg ? -1.0 : 1.0) * real'(mag) / 256.0;
    rad = ang * PI / 180.0;
    // R1 R2: results against real sine and cosine
    check_near({tag, " R1 R2 cos"}, int'(cos_out), $cos(rad) * 32768.0, TOL);
    check_near({tag, " R1 R2 sin"}, int'(sin_out), $sin(rad) * 32768.0, TOL);
    // R9
    check_eq({tag, " R9 cos positive"}, int'(cos_out > 0), 1);
    if (hold) begin
      c_keep = int'(cos_out);
      s_keep = int'(sin_out);
      ang_neg = ~neg;
      ang_mag = mag ^ 16'h0a5c;
      repeat (3) @(negedge clk);
      // R5: held outputs ignore new angle pins
      check_eq({tag, " R5 hold valid"}, int'(out_valid), 1);
      check_eq({tag, " R5 hold cos"}, int'(cos_out), c_keep);
      check_eq({tag, " R5 hold sin"}, int'(sin_out), s_keep);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);

    // R6: positive and negative zero
    run(1'b0, 16'd0, 1'b1, "pos-zero");
    run(1'b1, 16'd0, 1'b1, "R6 neg-zero");
    check_near("R6 neg-zero cos", int'(cos_out), 32768.0, TOL);
    check_near("R6 neg-zero sin", int'(sin_out), 0.0, TOL);

    // R7: endpoints and sign of the sine
    run(1'b0, 16'd11520, 1'b0, "R7 +45");
    check_eq("R7 +45 sin sign", int'(sin_out > 0), 1);
    // R8: fresh reset after a completed run, opposite angle
    run(1'b1, 16'd11520, 1'b1, "R7 R8 -45");
    check_eq("R7 R8 -45 sin sign", int'(sin_out < 0), 1);

    // R1 R2: sweep of the whole supported range, both signs
    for (int m = 1; m <= 11520; m += 13) begin
      run(1'b0, 16'(m), (m % 97) == 1, "sweep+");
      run(1'b1, 16'(m), 1'b0, "sweep-");
    end

    // R1: only the angle at the last reset edge counts
    @(negedge clk);
    rst = 1'b1; ang_neg = 1'b1; ang_mag = 16'd5000;
    run(1'b0, 16'd7680, 1'b0, "R1 last-edge");
    check_near("R1 last-edge sin", int'(sin_out), 0.5 * 32768.0, TOL);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule